// File: doc/BRIEF.md
# Reverse Playback Buffer Address Generator

This block drives the address side of a circular sample memory that is recorded forwards and played back backwards. A write pointer climbs through the buffer and a read pointer falls through it. Each pointer moves one step on every accepted sample tick, and each wraps within a buffer length that can change while the block runs. A second read tap sits half a buffer away from the first. The downstream mixer can then crossfade the two taps, so the jump at the buffer boundary is never heard at full level.

The active length does not jump to a new target. It slews toward the target by a fixed step of two on each tick. After reset the block first sweeps a clear address across the whole 16-bit memory, one location per clock, so that the memory controller can zero it. Sample ticks are ignored until that sweep is finished. The sample memory and the crossfade arithmetic sit outside this block. The memory controller is expected to write the incoming sample at the write address before it reads the two taps of the same tick.

Top module: `rev_buf_addr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cur_len` becomes 0x0600, `wr_addr` 0, `rd_addr_a` 0xFD00, `rd_addr_b` 0xFA00, `clr_busy` 1 and `clr_addr` 0.
- R2: On an accepted tick, `wr_addr` becomes `wr_addr`+1. If that sum is greater than or equal to the length in force before the tick, `wr_addr` becomes 0 instead.
- R3: On an accepted tick, `rd_addr_a` becomes `rd_addr_a`-1. If `rd_addr_a` was 0, it becomes the length in force before the tick minus one instead.
- R4: On an accepted tick, let H be the pre-tick length shifted right by one. If the new `rd_addr_a` is at least H, `rd_addr_b` becomes the new `rd_addr_a` minus H. Otherwise it becomes the new `rd_addr_a` plus H.
- R5: On an accepted tick, `cur_len` rises by 2 when it is below the target and falls by 2 when it is above the target. It holds when the two are equal.
- R6: Bit 0 of `target_len` is ignored, so the target is always treated as even.
- R7: After reset, `clr_addr` counts up by one each clock from 0 and `clr_busy` stays high for exactly 65536 clocks. `clr_busy` then stays low until the next reset.
- R8: A tick is accepted only when `clr_busy` is low. While `clr_busy` is high, `tick` has no effect on the pointers or on the length.
- R9: All outputs are registered. A tick sampled at a clock edge shows on the outputs after that edge, and with no accepted tick the pointers and the length hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Sample tick, one clock wide per sample |
| target_len | input | 16 | Requested buffer length (bit 0 ignored) |
| wr_addr | output | 16 | Write address for the incoming sample |
| rd_addr_a | output | 16 | Primary reverse read address |
| rd_addr_b | output | 16 | Second tap, half a buffer from the primary |
| cur_len | output | 16 | Active buffer length |
| clr_busy | output | 1 | High while the memory clear sweep runs |
| clr_addr | output | 16 | Address to zero during the sweep |

## Verification
The length logic is driven with a target equal to the current length, targets above and below it, and an odd target. These show holding, rising, falling and the masking of bit 0, and they show that the length stops exactly on an even target. A long run of back-to-back ticks with a shrinking length makes the write pointer wrap many times and takes the read pointer through its single borrow from the post-reset address. Along the way the second tap passes through both its add branch and its subtract branch. Holding `tick` high during the clear sweep shows the tick being ignored, and counting clocks to the fall of `clr_busy` pins the sweep length to 65536 clocks.

// File: rtl/rev_pkg.sv
// Package: shared helpers for the reverse buffer address generator.
// Assumes callers widen their operands to 32 bits and truncate the result.
package rev_pkg;

    // Direction of the length slew for one tick
    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_dir_t;

    // Address half a buffer away from rd, staying inside [0, len)
    function automatic logic [31:0] far_tap(input logic [31:0] rd, input logic [31:0] len);
        logic [31:0] half;
        half = len >> 1;
        return (rd >= half) ? (rd - half) : (rd + half);
    endfunction

endpackage

// File: rtl/rev_clear_seq.sv
// Module: memory clear sequencer.
// After reset it walks an address across all 2**ADDR_W locations, one per
// clock, and holds busy high until the last one is issued.
// Assumes synchronous active-low reset.
module rev_clear_seq #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              busy,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    // Sweep the clear address; drop busy after the last location
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b1;
            addr <= '0;
        end else if (busy) begin
            if (addr == LAST_ADDR) busy <= 1'b0;
            else                   addr <= addr + 1'b1;
        end
    end

    AST_CLR_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || addr == $past(addr) + 1'b1)); // R7
    AST_CLR_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy); // R7
endmodule

// File: rtl/rev_len_slew.sv
// Module: buffer length slew.
// On each accepted tick the length moves STEP toward the even-masked target.
// Assumes STEP divides the distance between even values (STEP = 2).
module rev_len_slew
    import rev_pkg::*;
#(
    parameter int              ADDR_W  = 16,
    parameter int              STEP    = 2,
    parameter logic [ADDR_W-1:0] RST_LEN = 16'h0600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] len
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] tgt_even;
    slew_dir_t         dir;

    // Mask the target to even and pick the slew direction
    always_comb begin
        tgt_even = {target[ADDR_W-1:1], 1'b0};
        if (len < tgt_even)      dir = SLEW_UP;
        else if (len > tgt_even) dir = SLEW_DOWN;
        else                     dir = SLEW_HOLD;
    end

    // Apply one slew step per accepted tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= RST_LEN;
        end else if (step_en) begin
            case (dir)
                SLEW_UP:   len <= len + STEP_V;
                SLEW_DOWN: len <= len - STEP_V;
                default:   len <= len;
            endcase
        end
    end

    AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (len == $past(len) || len == $past(len) + STEP_V
                     || len == $past(len) - STEP_V)); // R5
    AST_LEN_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(len)); // R8
endmodule

// File: rtl/rev_ptr_gen.sv
// Module: write / reverse-read pointer pair with the opposite tap.
// On each accepted tick the write pointer climbs and the read pointer falls,
// both wrapping on the length in force before the tick; the second tap is
// registered from the new read pointer. Assumes len > 0 in normal use.
module rev_ptr_gen
    import rev_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RST_LEN = 16'h0600,
    parameter logic [ADDR_W-1:0] RST_RD  = 16'hFD00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [ADDR_W-1:0] len,
    output logic [ADDR_W-1:0] wr,
    output logic [ADDR_W-1:0] rd_a,
    output logic [ADDR_W-1:0] rd_b
);
    localparam logic [ADDR_W-1:0] RST_TAP = ADDR_W'(far_tap(32'(RST_RD), 32'(RST_LEN)));

    logic [ADDR_W:0]   wr_inc;
    logic [ADDR_W-1:0] wr_nxt;
    logic [ADDR_W-1:0] rd_nxt;
    logic [ADDR_W-1:0] tap_nxt;

    // Next pointer values and the tap from the next read pointer
    always_comb begin
        wr_inc  = {1'b0, wr} + 1'b1;
        wr_nxt  = (wr_inc >= {1'b0, len}) ? '0 : wr_inc[ADDR_W-1:0];
        rd_nxt  = (rd_a == '0) ? (len - 1'b1) : (rd_a - 1'b1);
        tap_nxt = ADDR_W'(far_tap(32'(rd_nxt), 32'(len)));
    end

    // Register pointers and tap on accepted ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr   <= '0;
            rd_a <= RST_RD;
            rd_b <= RST_TAP;
        end else if (step_en) begin
            wr   <= wr_nxt;
            rd_a <= rd_nxt;
            rd_b <= tap_nxt;
        end
    end

    AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (wr == '0 || wr == $past(wr) + 1'b1)); // R2
    AST_RD_RETREAT: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (rd_a == $past(rd_a) - 1'b1 || rd_a == $past(len) - 1'b1)); // R3
    AST_TAP_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (rd_b == rd_a + ($past(len) >> 1)
                     || rd_b == rd_a - ($past(len) >> 1))); // R4
    AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(wr) && $stable(rd_a) && $stable(rd_b))); // R9
endmodule

// File: rtl/rev_buf_addr.sv
// Module: reverse playback buffer address generator (top).
// Gates sample ticks with the clear sweep, then drives the pointer pair and
// the length slew. Assumes the memory controller writes at wr_addr before
// reading both taps of the same tick.
module rev_buf_addr #(
    parameter int                ADDR_W  = 16,
    parameter int                STEP    = 2,
    parameter logic [ADDR_W-1:0] RST_LEN = 16'h0600,
    parameter logic [ADDR_W-1:0] RST_RD  = 16'hFD00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] target_len,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output logic [ADDR_W-1:0] cur_len,
    output logic              clr_busy,
    output logic [ADDR_W-1:0] clr_addr
);
    logic tick_ok;

    // Accept ticks only once the clear sweep has finished
    always_comb tick_ok = tick & ~clr_busy;

    rev_clear_seq #(.ADDR_W(ADDR_W)) u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (clr_busy),
        .addr  (clr_addr)
    );

    rev_len_slew #(.ADDR_W(ADDR_W), .STEP(STEP), .RST_LEN(RST_LEN)) u_slew (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (tick_ok),
        .target  (target_len),
        .len     (cur_len)
    );

    rev_ptr_gen #(.ADDR_W(ADDR_W), .RST_LEN(RST_LEN), .RST_RD(RST_RD)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (tick_ok),
        .len     (cur_len),
        .wr      (wr_addr),
        .rd_a    (rd_addr_a),
        .rd_b    (rd_addr_b)
    );

    AST_BUSY_BLOCKS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> ($stable(wr_addr) && $stable(rd_addr_a) && $stable(cur_len))); // R8
endmodule

// File: tb/test_rev_buf_addr.sv
module test_rev_buf_addr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] target_len = 16'h0600;
    logic [15:0] wr_addr, rd_addr_a, rd_addr_b, cur_len, clr_addr;
    logic        clr_busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state kept from the requirements
    logic [15:0] m_wr, m_rd, m_tap, m_len;

    always #5 clk = ~clk;

    rev_buf_addr i_rev_buf_addr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .target_len(target_len),
        .wr_addr(wr_addr), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .cur_len(cur_len), .clr_busy(clr_busy), .clr_addr(clr_addr)
    );

    // Stimulus: target, tick count, expected length afterwards
    localparam logic [47:0] VEC [5] = '{
        {16'h0600, 16'd4,  16'h0600},
        {16'h0610, 16'd4,  16'h0608},
        {16'h0610, 16'd10, 16'h0610},
        {16'h0601, 16'd10, 16'h0600},
        {16'h0200, 16'd4,  16'h05F8}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [16:0] inc;
        logic [15:0] half, te;
        inc  = {1'b0, m_wr} + 17'd1;
        m_wr = (inc >= {1'b0, m_len}) ? 16'h0 : inc[15:0];
        m_rd = (m_rd == 16'h0) ? m_len - 16'd1 : m_rd - 16'd1;
        half = m_len >> 1;
        m_tap = (m_rd >= half) ? m_rd - half : m_rd + half;
        te = {target_len[15:1], 1'b0};
        if (m_len < te)      m_len = m_len + 16'd2;
        else if (m_len > te) m_len = m_len - 16'd2;
    endtask

    task automatic run_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_step();
            chk("R2 wr_addr", wr_addr, m_wr);
            chk("R3 rd_addr_a", rd_addr_a, m_rd);
            chk("R4 rd_addr_b", rd_addr_b, m_tap);
            chk("R5 cur_len", cur_len, m_len);
        end
        tick = 1'b0;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R7 watchdog act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cur_len", cur_len, 16'h0600);
        chk("R1 wr_addr", wr_addr, 16'h0000);
        chk("R1 rd_addr_a", rd_addr_a, 16'hFD00);
        chk("R1 rd_addr_b", rd_addr_b, 16'hFA00);
        chk("R1 clr_busy", {15'd0, clr_busy}, 16'd1);
        chk("R1 clr_addr", clr_addr, 16'h0000);
        m_wr = 16'h0; m_rd = 16'hFD00; m_tap = 16'hFA00; m_len = 16'h0600;

        // R8: ticks during the sweep are ignored; R7 sweep count
        rst_n = 1'b1;
        tick = 1'b1;
        target_len = 16'h0800;
        repeat (100) @(negedge clk);
        chk("R8 wr_addr", wr_addr, 16'h0000);
        chk("R8 rd_addr_a", rd_addr_a, 16'hFD00);
        chk("R8 cur_len", cur_len, 16'h0600);
        chk("R7 clr_addr", clr_addr, 16'd100);
        tick = 1'b0;
        target_len = 16'h0600;
        repeat (65535 - 100) @(negedge clk);
        chk("R7 busy before end", {15'd0, clr_busy}, 16'd1);
        chk("R7 last clr_addr", clr_addr, 16'hFFFF);
        @(negedge clk);
        chk("R7 busy after end", {15'd0, clr_busy}, 16'd0);

        // Table of length-slew vectors (R5, R6), then idle hold (R9)
        for (int v = 0; v < 5; v++) begin
            target_len = VEC[v][47:32];
            run_ticks(int'(VEC[v][31:16]));
            chk("R5 R6 table length", cur_len, VEC[v][15:0]);
            @(negedge clk);
            chk("R9 idle wr_addr", wr_addr, m_wr);
            chk("R9 idle rd_addr_a", rd_addr_a, m_rd);
            chk("R9 idle cur_len", cur_len, m_len);
        end

        // Long run: read pointer borrows, write pointer wraps often
        target_len = 16'h0400;
        run_ticks(64800);
        chk("R5 long-run length", cur_len, 16'h0400);
        chk("R7 busy stays low", {15'd0, clr_busy}, 16'd0);

        // R1: reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset cur_len", cur_len, 16'h0600);
        chk("R1 re-reset wr_addr", wr_addr, 16'h0000);
        chk("R1 re-reset rd_addr_a", rd_addr_a, 16'hFD00);
        chk("R1 re-reset rd_addr_b", rd_addr_b, 16'hFA00);
        chk("R1 re-reset clr_busy", {15'd0, clr_busy}, 16'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule